// File: doc/BRIEF.md
# Debug Event Interrupt Controller

This block raises one debug interrupt line per processor. Two kinds of event drive it. A debugger message is aimed at a single processor, and no mask applies to it. An abort either goes to every processor at once or comes from a bus write that names single processors, and a mask bit gates it for each processor. Each processor has two source bits in a status word, one for messages and one for aborts. A processor's interrupt line stays high while either of its two bits is set.

Software reads the status word through a small peripheral-bus port. It clears a bit by writing 1 to it. A separate write-only address takes the per-processor abort requests. The abort mask is not visible on the bus. It is loaded only from the scan path, and only at the Update-DR strobe while the mask-scan instruction is decoded. Events from the debug port arrive as single-cycle strobes that are already synchronous to the system clock.

Top module: `dbg_event_irq`

## Requirements
- R1: On chip reset (rstN low) every source bit is 0, every interrupt line is low and every mask bit is 1. The source and mask registers have no other reset.
- R2: The mask register takes the value of maskShiftIn only in a cycle where updDr and instScanMask are both high. At all other times it holds, and no bus write changes it.
- R3: updDr with instScanRx and a target ID below NUM_PROC sets the RX bit of that processor, whatever the mask holds. The interrupt line of that processor is high from the next cycle.
- R4: updDr with instScanRx and target ID 4'b1111 requests an abort for every processor. The ABORT bit of processor i is set only if mask bit i is 1. The mask value used is the one held before that edge.
- R5: A bus write to address 1 (the abort-request register) requests an abort for each processor i whose data bit i is 1, subject to mask bit i. The write takes effect on the same edge. Processors written with 0 are left unchanged. A read of address 1 returns 0.
- R6: A bus write to address 0 clears each source bit whose data bit is 1. Data bits that are 0 leave their source bits unchanged.
- R7: dbgIrq[i] is high exactly when RX bit i or ABORT bit i is set.
- R8: If an event for a processor arrives on the same edge as a clear of that processor's bit, the bit ends set and the interrupt stays high. A new source that arrives while the interrupt is already high is also recorded.
- R9: A scan-receive target ID from NUM_PROC through 4'b1110 changes no source bit.
- R10: A read of address 0 returns the RX bits in [3:0] and the ABORT bits in [7:4]. Any other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Chip reset, active low, asynchronous |
| busWrEn | input | 1 | Bus write strobe |
| busAddr | input | 1 | Register select: 0 = source, 1 = abort request |
| busWrData | input | BUS_W | Bus write data |
| busRdData | output | BUS_W | Read data for the selected register |
| updDr | input | 1 | Update-DR strobe, one cycle |
| instScanRx | input | 1 | Scan-receive instruction is loaded |
| instScanMask | input | 1 | Mask-scan instruction is loaded |
| rxTargetId | input | 4 | Target ID from the scan-receive payload |
| maskShiftIn | input | NUM_PROC | Mask value shifted in by the scan chain |
| dbgIrq | output | NUM_PROC | Debug interrupt line, one per processor |

## Verification
The bench builds the block with its default four processors and an 8-bit bus. At that size the source word fills the bus exactly. The 4-bit target ID then covers all three cases: a valid processor, the ignored range from 4 to 14, and the broadcast value 15. Random traffic mixes clears, abort requests, messages and mask loads on the same edges, so same-cycle set-versus-clear collisions and masked broadcasts occur often. Directed steps pin down the reset state, a fully masked broadcast and an ignored target ID.

// File: rtl/dbg_event_irq_pkg.sv
package dbg_event_irq_pkg;
  parameter int unsigned DBG_PROCS = 4;
  parameter int unsigned DBG_ID_W = 4;

  typedef struct packed {
    logic [DBG_PROCS-1:0] setRx;
    logic [DBG_PROCS-1:0] abortReq;
    logic [DBG_PROCS-1:0] clrRx;
    logic [DBG_PROCS-1:0] clrAbort;
    logic                 loadMask;
  } dbgStrobes_t;
endpackage

// File: rtl/dbg_event_ctrl.sv
module dbg_event_ctrl
  import dbg_event_irq_pkg::*;
#(
  parameter int unsigned BUS_W = 8
) (
  input  logic                busWrEn,
  input  logic                busAddr,
  input  logic [BUS_W-1:0]    busWrData,
  input  logic                updDr,
  input  logic                instScanRx,
  input  logic                instScanMask,
  input  logic [DBG_ID_W-1:0] rxTargetId,
  output dbgStrobes_t         strobes
);
  localparam logic [DBG_ID_W-1:0] BCAST_ID = '1;

  logic srcWrite;
  logic abortWrite;
  logic scanRx;

  assign srcWrite   = busWrEn && (busAddr == 1'b0);
  assign abortWrite = busWrEn && (busAddr == 1'b1);
  assign scanRx     = updDr && instScanRx;

  always_comb begin
    strobes = '0;
    if (srcWrite) begin
      strobes.clrRx    = busWrData[DBG_PROCS-1:0];
      strobes.clrAbort = busWrData[2*DBG_PROCS-1:DBG_PROCS];
    end
    if (abortWrite) begin
      strobes.abortReq = busWrData[DBG_PROCS-1:0];
    end
    if (scanRx) begin
      if (rxTargetId == BCAST_ID) begin
        strobes.abortReq = '1;
      end else begin
        for (int i = 0; i < DBG_PROCS; i++) begin
          if (rxTargetId == DBG_ID_W'(i)) strobes.setRx[i] = 1'b1;
        end
      end
    end
    strobes.loadMask = updDr && instScanMask;
  end
endmodule

// File: rtl/dbg_event_dp.sv
module dbg_event_dp
  import dbg_event_irq_pkg::*;
#(
  parameter int unsigned BUS_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dbgStrobes_t          strobes,
  input  logic [DBG_PROCS-1:0] maskShiftIn,
  input  logic                 busAddr,
  output logic [BUS_W-1:0]     busRdData,
  output logic [DBG_PROCS-1:0] srcRx,
  output logic [DBG_PROCS-1:0] srcAbort,
  output logic [DBG_PROCS-1:0] maskQ,
  output logic [DBG_PROCS-1:0] dbgIrq
);
  localparam int unsigned SRC_W = 2 * DBG_PROCS;

  genvar g;
  generate
    for (g = 0; g < DBG_PROCS; g++) begin : g_proc
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          srcRx[g]    <= 1'b0;
          srcAbort[g] <= 1'b0;
          maskQ[g]    <= 1'b1;
        end else begin
          srcRx[g]    <= (srcRx[g] & ~strobes.clrRx[g]) | strobes.setRx[g];
          srcAbort[g] <= (srcAbort[g] & ~strobes.clrAbort[g])
                       | (strobes.abortReq[g] & maskQ[g]);
          if (strobes.loadMask) maskQ[g] <= maskShiftIn[g];
        end
      end
      assign dbgIrq[g] = srcRx[g] | srcAbort[g];
    end
  endgenerate

  always_comb begin
    busRdData = '0;
    if (busAddr == 1'b0) busRdData[SRC_W-1:0] = {srcAbort, srcRx};
  end
endmodule

// File: rtl/dbg_event_irq.sv
module dbg_event_irq
  import dbg_event_irq_pkg::*;
#(
  parameter int unsigned NUM_PROC = DBG_PROCS,
  parameter int unsigned BUS_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic                busAddr,
  input  logic [BUS_W-1:0]    busWrData,
  output logic [BUS_W-1:0]    busRdData,
  input  logic                updDr,
  input  logic                instScanRx,
  input  logic                instScanMask,
  input  logic [DBG_ID_W-1:0] rxTargetId,
  input  logic [NUM_PROC-1:0] maskShiftIn,
  output logic [NUM_PROC-1:0] dbgIrq
);
  dbgStrobes_t         strobes;
  logic [NUM_PROC-1:0] srcRx;
  logic [NUM_PROC-1:0] srcAbort;
  logic [NUM_PROC-1:0] maskQ;

  dbg_event_ctrl #(.BUS_W(BUS_W)) u_ctrl (
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .updDr(updDr), .instScanRx(instScanRx), .instScanMask(instScanMask),
    .rxTargetId(rxTargetId), .strobes(strobes)
  );

  dbg_event_dp #(.BUS_W(BUS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .maskShiftIn(maskShiftIn),
    .busAddr(busAddr), .busRdData(busRdData), .srcRx(srcRx),
    .srcAbort(srcAbort), .maskQ(maskQ), .dbgIrq(dbgIrq)
  );
endmodule

// File: rtl/dbg_event_irq_chk.sv
module dbg_event_irq_chk #(
  parameter int unsigned NUM_PROC = 4,
  parameter int unsigned BUS_W    = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWrEn,
  input logic                busAddr,
  input logic [BUS_W-1:0]    busWrData,
  input logic                updDr,
  input logic                instScanRx,
  input logic                instScanMask,
  input logic [3:0]          rxTargetId,
  input logic [NUM_PROC-1:0] srcRx,
  input logic [NUM_PROC-1:0] srcAbort,
  input logic [NUM_PROC-1:0] maskQ,
  input logic [NUM_PROC-1:0] dbgIrq
);
  a_r2_mask_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(updDr && instScanMask) |=> $stable(maskQ));

  genvar g;
  generate
    for (g = 0; g < NUM_PROC; g++) begin : g_chk
      a_r3_message_sets_rx: assert property (@(posedge clk) disable iff (!rstN)
        (updDr && instScanRx && rxTargetId == 4'(g)) |=> (srcRx[g] && dbgIrq[g]));

      a_r4_bcast_enabled: assert property (@(posedge clk) disable iff (!rstN)
        (updDr && instScanRx && rxTargetId == 4'hF && maskQ[g]) |=> srcAbort[g]);

      a_r4_bcast_masked: assert property (@(posedge clk) disable iff (!rstN)
        (updDr && instScanRx && rxTargetId == 4'hF && !maskQ[g] && !srcAbort[g])
        |=> !srcAbort[g]);

      a_r6_zero_write_keeps: assert property (@(posedge clk) disable iff (!rstN)
        (busWrEn && !busAddr && srcRx[g] && !busWrData[g]) |=> srcRx[g]);

      a_r7_irq_high: assert property (@(posedge clk) disable iff (!rstN)
        (srcRx[g] || srcAbort[g]) |-> dbgIrq[g]);

      a_r7_irq_low: assert property (@(posedge clk) disable iff (!rstN)
        (!srcRx[g] && !srcAbort[g]) |-> !dbgIrq[g]);
    end
  endgenerate
endmodule

bind dbg_event_irq dbg_event_irq_chk #(.NUM_PROC(NUM_PROC), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .updDr(updDr), .instScanRx(instScanRx),
  .instScanMask(instScanMask), .rxTargetId(rxTargetId), .srcRx(srcRx),
  .srcAbort(srcAbort), .maskQ(maskQ), .dbgIrq(dbgIrq)
);

// File: tb/dbg_event_irq_bench.sv
module dbg_event_irq_bench;
  localparam int  NP = 4;
  localparam int  BW = 8;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWrEn = 1'b0;
  logic          busAddr = 1'b0;
  logic [BW-1:0] busWrData = '0;
  logic [BW-1:0] busRdData;
  logic          updDr = 1'b0;
  logic          instScanRx = 1'b0;
  logic          instScanMask = 1'b0;
  logic [3:0]    rxTargetId = '0;
  logic [NP-1:0] maskShiftIn = '0;
  logic [NP-1:0] dbgIrq;

  int checks = 0;
  int errors = 0;
  logic [NP-1:0] mRx, mAb, mMask;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_event_irq #(.NUM_PROC(NP), .BUS_W(BW)) u_dbg_event_irq (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .updDr(updDr),
    .instScanRx(instScanRx), .instScanMask(instScanMask),
    .rxTargetId(rxTargetId), .maskShiftIn(maskShiftIn), .dbgIrq(dbgIrq)
  );

  function automatic logic [NP-1:0] nextRx(logic [NP-1:0] rx);
    logic [NP-1:0] r = rx;
    if (busWrEn && !busAddr) r &= ~busWrData[NP-1:0];
    if (updDr && instScanRx && rxTargetId < 4'(NP)) r[rxTargetId[1:0]] = 1'b1;
    return r;
  endfunction

  function automatic logic [NP-1:0] nextAb(logic [NP-1:0] ab, logic [NP-1:0] mk);
    logic [NP-1:0] a = ab;
    logic [NP-1:0] req = '0;
    if (busWrEn && !busAddr) a &= ~busWrData[2*NP-1:NP];
    if (busWrEn && busAddr) req |= busWrData[NP-1:0];
    if (updDr && instScanRx && rxTargetId == 4'hF) req = '1;
    return a | (req & mk);
  endfunction

  task automatic check(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idleIns();
    busWrEn = 1'b0; busAddr = 1'b0; busWrData = '0; updDr = 1'b0;
    instScanRx = 1'b0; instScanMask = 1'b0; rxTargetId = '0; maskShiftIn = '0;
  endtask

  // Inputs already driven at a falling edge; advance one clock and compare.
  task automatic stepAndCheck(string req);
    logic [NP-1:0] nr = nextRx(mRx);
    logic [NP-1:0] na = nextAb(mAb, mMask);
    if (updDr && instScanMask) mMask = maskShiftIn;
    mRx = nr; mAb = na;
    @(negedge clk);
    idleIns();
    #1;
    check({req, " R7 irq"}, BW'(dbgIrq), BW'(mRx | mAb));
    check({req, " R10 src read"}, busRdData, {mAb, mRx});
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    mRx = '0; mAb = '0; mMask = '1;
    idleIns();
    repeat (3) @(negedge clk);
    #1;
    check("R1 irq at reset", BW'(dbgIrq), '0);
    check("R1 src at reset", busRdData, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: mask resets to ones, so a broadcast hits everyone
    updDr = 1; instScanRx = 1; rxTargetId = 4'hF;
    stepAndCheck("R1 R4 bcast all enabled");
    // R6: write zeros does nothing, then clear all with ones
    busWrEn = 1; busAddr = 0; busWrData = 8'h00;
    stepAndCheck("R6 write zero");
    busWrEn = 1; busAddr = 0; busWrData = 8'hFF;
    stepAndCheck("R6 clear all");
    // R2: a bus write to either address leaves the mask; load mask 0
    updDr = 1; instScanMask = 1; maskShiftIn = 4'b0000;
    stepAndCheck("R2 load mask zero");
    updDr = 1; instScanRx = 1; rxTargetId = 4'hF;
    stepAndCheck("R4 bcast fully masked");
    busWrEn = 1; busAddr = 1; busWrData = 8'h0F;
    stepAndCheck("R5 abort req masked");
    // R3: message ignores mask
    updDr = 1; instScanRx = 1; rxTargetId = 4'd2;
    stepAndCheck("R3 message unmasked");
    // R9: out-of-range ID
    updDr = 1; instScanRx = 1; rxTargetId = 4'd9;
    stepAndCheck("R9 id ignored");
    // R5: partial abort request with mask 0101
    updDr = 1; instScanMask = 1; maskShiftIn = 4'b0101;
    stepAndCheck("R2 load mask 0101");
    busWrEn = 1; busAddr = 1; busWrData = 8'h07;
    stepAndCheck("R5 partial abort");
    busAddr = 1; #1;
    check("R5 abort reg reads zero", busRdData, '0);
    busAddr = 0;
    // R8: clear RX2 while a new message hits processor 2
    busWrEn = 1; busAddr = 0; busWrData = 8'h04;
    updDr = 1; instScanRx = 1; rxTargetId = 4'd2;
    stepAndCheck("R8 set wins over clear");

    for (int n = 0; n < 3000; n++) begin
      busWrEn      = ($urandom_range(0, 2) == 0);
      busAddr      = 1'($urandom_range(0, 1));
      busWrData    = 8'($urandom);
      updDr        = ($urandom_range(0, 2) == 0);
      instScanRx   = 1'($urandom_range(0, 1));
      instScanMask = !instScanRx && ($urandom_range(0, 3) == 0);
      rxTargetId   = ($urandom_range(0, 3) == 0) ? 4'hF : 4'($urandom);
      maskShiftIn  = NP'($urandom);
      stepAndCheck("R8 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule